// File: doc/BRIEF.md
# Polled Byte-Wide SPI Master

This block is a serial peripheral master that software drives through three small registers: a byte-wide data register, a 16-bit control word and a two-flag status word. A write to the data register launches one full-duplex exchange of eight bits. The byte is sent on the serial output most significant bit first, and at the same time eight bits are gathered from the serial input. When the last bit has been taken in, the received byte becomes readable in the data register and a receive-full flag is raised. Software polls the status word to learn when the engine is free and when a fresh byte is waiting.

The control word sets the enable, the clock idle level, the clock phase and a 7-bit rate divider. The serial clock changes level once every divider-plus-one system clocks, so one bit period lasts twice that. Device select is not part of this block; a separate general-purpose output drives it. A read-only transfer is done by writing a zero byte and reading back what arrived.

Top module: `byte_spi_master`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x0000 and the serial clock is low.
- R2: Writing the control word (offset 2) keeps bit 0 (enable), bit 7 (phase), bit 8 (idle level) and bits 15:9 (divider); the remaining bits read back as zero.
- R3: A data write (offset 0) while enabled and idle raises busy on the next clock; busy then stays high for exactly 16 × (divider + 1) system clocks.
- R4: The written byte appears on the serial output most significant bit first, and the byte read back from offset 0 equals the eight input bits taken during the exchange, first one in the most significant position.
- R5: During an exchange the serial clock makes 16 level changes spaced (divider + 1) system clocks apart; whenever the engine is idle the clock sits at the level of control bit 8.
- R6: With control bit 7 clear, input is taken on each leading clock edge and the output bit changes on trailing edges (the first bit is present before the first edge); with bit 7 set, the output changes on leading edges and input is taken on trailing edges.
- R7: Completion of an exchange sets the receive-full flag; a read of offset 0 returns the received byte and clears the flag.
- R8: A data write while busy is ignored: the running exchange keeps its byte and its length.
- R9: A data write while the enable bit is clear is ignored and starts nothing.
- R10: Writing the control word with the enable bit clear stops a running exchange at once: busy is low and the serial clock is back at its idle level one clock later, and no receive-full flag is raised.
- R11: The status word (offset 4) carries busy in bit 0 and receive-full in bit 1, all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register byte offset: 0 data, 2 control, 4 status |
| reg_wr | input | 1 | Write strobe, one clock per access |
| reg_rd | input | 1 | Read strobe, one clock per access |
| reg_wdata | input | 16 | Write data (data register uses bits 7:0) |
| reg_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data toward the device |
| miso | input | 1 | Serial data from the device |

## Verification
The assertions assume that, once an exchange is running, software touches the control word only to clear the enable bit, so the idle level and divider they compare against stay fixed for the whole exchange, and that every register strobe lasts a single clock. The bench follows this: it reprograms mode and divider only while status shows idle, keeps abort writes at the same idle level, and drives each strobe for exactly one cycle between falling edges. A device model in the bench answers on the serial clock edges according to the programmed phase, so received and transmitted bytes are judged against the mode rules rather than against the engine's own timing.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    // Register byte offsets
    localparam int OFS_DATA = 0;
    localparam int OFS_CTRL = 2;
    localparam int OFS_STAT = 4;

    // Control word field positions
    localparam int EN_POS   = 0;
    localparam int CPHA_POS = 7;
    localparam int CPOL_POS = 8;
    localparam int DIV_LSB  = 9;

    // Status word field positions
    localparam int BUSY_POS = 0;
    localparam int FULL_POS = 1;

endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
    import spi_byte_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 7,
    parameter int ADDR_W = 3,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              en,
    output logic              cpha,
    output logic              cpol,
    output logic [DIV_W-1:0]  div,
    output logic              start,
    output logic              abort,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_full
);

    localparam logic [REG_W-1:0] CTRL_MASK =
        REG_W'((1 << EN_POS) | (1 << CPHA_POS) | (1 << CPOL_POS) |
               (((1 << DIV_W) - 1) << DIV_LSB));

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic [REG_W-1:0]  ctrl;
        logic [DATA_W-1:0] rx;
        logic              full;
    } regs_t;

    regs_t q, d;
    logic  data_wr, ctrl_wr, data_rd;

    always_comb begin
        d       = q;
        data_wr = reg_wr && (reg_addr == A_DATA);
        ctrl_wr = reg_wr && (reg_addr == A_CTRL);
        data_rd = reg_rd && (reg_addr == A_DATA);

        start   = data_wr && q.ctrl[EN_POS] && !busy;
        abort   = ctrl_wr && !reg_wdata[EN_POS];
        tx_byte = reg_wdata[DATA_W-1:0];

        if (ctrl_wr) begin
            d.ctrl = reg_wdata & CTRL_MASK;
        end
        if (data_rd) begin
            d.full = 1'b0;
        end
        if (done) begin
            d.rx   = rx_byte;
            d.full = 1'b1;
        end

        unique case (reg_addr)
            A_DATA:  reg_rdata = {{(REG_W-DATA_W){1'b0}}, q.rx};
            A_CTRL:  reg_rdata = q.ctrl;
            A_STAT: begin
                reg_rdata           = '0;
                reg_rdata[BUSY_POS] = busy;
                reg_rdata[FULL_POS] = q.full;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign en      = q.ctrl[EN_POS];
    assign cpha    = q.ctrl[CPHA_POS];
    assign cpol    = q.ctrl[CPOL_POS];
    assign div     = q.ctrl[DIV_LSB +: DIV_W];
    assign rx_full = q.full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spi_byte_sck.sv
module spi_byte_sck #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             abort,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             tick,
    output logic             lead
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } sck_t;

    sck_t q, d;

    always_comb begin
        d    = q;
        tick = 1'b0;
        lead = 1'b0;
        if (!run || abort) begin
            // Idle or stopping: park the clock at its rest level
            d.cnt  = '0;
            d.sclk = cpol;
        end else if (q.cnt == div) begin
            tick   = 1'b1;
            lead   = (q.sclk == cpol);
            d.cnt  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign sclk = q.sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cpha,
    input  logic              tick,
    input  logic              lead,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              mosi
);

    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    typedef struct packed {
        logic              busy;
        logic [EW-1:0]     edge_n;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              mosi;
    } sh_t;

    sh_t  q, d;
    logic sample;

    always_comb begin
        d      = q;
        done   = 1'b0;
        sample = lead ^ cpha;
        if (abort) begin
            d.busy   = 1'b0;
            d.edge_n = '0;
        end else if (start) begin
            d.busy   = 1'b1;
            d.edge_n = '0;
            d.rx     = '0;
            if (cpha) begin
                d.tx = tx_byte;
            end else begin
                d.mosi = tx_byte[DATA_W-1];
                d.tx   = tx_byte << 1;
            end
        end else if (q.busy && tick) begin
            d.edge_n = q.edge_n + 1'b1;
            if (sample) begin
                d.rx = {q.rx[DATA_W-2:0], miso};
            end else begin
                d.mosi = q.tx[DATA_W-1];
                d.tx   = q.tx << 1;
            end
            if (q.edge_n == LAST) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end
        end
    end

    assign busy    = q.busy;
    assign mosi    = q.mosi;
    assign rx_byte = d.rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 7,
    parameter int ADDR_W = 3,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    logic              busy_w, done_w, en_w, cpha_w, cpol_w;
    logic              start_w, abort_w, tick_w, lead_w, full_w;
    logic [DIV_W-1:0]  div_w;
    logic [DATA_W-1:0] tx_w, rxb_w;

    spi_byte_regs #(
        .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .done(done_w), .rx_byte(rxb_w),
        .en(en_w), .cpha(cpha_w), .cpol(cpol_w), .div(div_w),
        .start(start_w), .abort(abort_w), .tx_byte(tx_w), .rx_full(full_w)
    );

    spi_byte_sck #(.DIV_W(DIV_W)) sck_i (
        .clk(clk), .rst_n(rst_n),
        .run(busy_w), .abort(abort_w), .cpol(cpol_w), .div(div_w),
        .sclk(sclk), .tick(tick_w), .lead(lead_w)
    );

    spi_byte_shift #(.DATA_W(DATA_W)) shift_i (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .abort(abort_w), .tx_byte(tx_w), .cpha(cpha_w),
        .tick(tick_w), .lead(lead_w), .miso(miso),
        .busy(busy_w), .done(done_w), .rx_byte(rxb_w), .mosi(mosi)
    );

endmodule

// File: rtl/byte_spi_master_chk.sv
module byte_spi_master_chk
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              wdata_en,
    input logic              sclk,
    input logic              busy,
    input logic              done,
    input logic              rx_full,
    input logic              en,
    input logic              cpol
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    // R3: an accepted data write launches an exchange
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DATA && en && !busy) |=> busy)
        else $error("a_r3_start_busy");

    // R9: a data write while disabled starts nothing
    a_r9_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DATA && !en && !busy) |=> !busy)
        else $error("a_r9_disabled_write");

    // R10: clearing enable stops the engine and parks the clock
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !wdata_en) |=> (!busy && sclk == $past(cpol)))
        else $error("a_r10_abort_idle");

    // R5: an idle engine holds the clock at the programmed rest level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sclk == $past(cpol)))
        else $error("a_r5_idle_level");

    // R7: completion raises receive-full and frees the engine
    a_r7_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_full && !busy))
        else $error("a_r7_done_sets_full");

    // R7: reading the data register drops receive-full
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && !done) |=> !rx_full)
        else $error("a_r7_read_clears");

endmodule

bind byte_spi_master byte_spi_master_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wdata_en(reg_wdata[spi_byte_pkg::EN_POS]),
    .sclk(sclk), .busy(busy_w), .done(done_w), .rx_full(full_w),
    .en(en_w), .cpol(cpol_w)
);

// File: tb/byte_spi_master_tb_top.sv
`timescale 1ns/1ps
module byte_spi_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    byte_spi_master dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // ---------------- device model ----------------
    logic       slv_on = 1'b0;
    logic       t_cpol = 1'b0, t_cpha = 1'b0;
    logic [7:0] slv_tx = '0, slv_rx = '0;
    int         slv_edges = 0, gap_err = 0, t_half = 10;
    longint     last_t = -1;

    always @(sclk) begin
        if (slv_on) begin
            slv_edges++;
            if (last_t >= 0 && ($time - last_t) != longint'(t_half)) gap_err++;
            last_t = $time;
            if (sclk != t_cpol) begin
                if (!t_cpha) slv_rx = {slv_rx[6:0], mosi};
                else begin
                    miso   = slv_tx[7];
                    slv_tx = slv_tx << 1;
                end
            end else begin
                if (!t_cpha) begin
                    slv_tx = slv_tx << 1;
                    miso   = slv_tx[7];
                end else slv_rx = {slv_rx[6:0], mosi};
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] ctrl_word(input logic en, input logic pol,
                                              input logic pha, input logic [6:0] dv);
        return {dv, pol, pha, 6'b0, en};
    endfunction

    // Poll status at falling edges; returns busy cycles seen
    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 3'd4;
        #1;
        while (reg_rdata[0] && n < 5000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic arm_slave(input logic pol, input logic pha, input logic [6:0] dv,
                             input logic [7:0] sv);
        t_cpol = pol; t_cpha = pha; t_half = (int'(dv) + 1) * 10;
        slv_tx = sv; slv_rx = '0; slv_edges = 0; gap_err = 0; last_t = -1;
        miso = sv[7];
        slv_on = 1'b1;
    endtask

    // {cpol, cpha, div, tx byte, device byte}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 1'b0, 7'd0,   8'hA5, 8'h3C},
        {1'b0, 1'b1, 7'd1,   8'h81, 8'hC3},
        {1'b1, 1'b0, 7'd2,   8'h5A, 8'h96},
        {1'b1, 1'b1, 7'd3,   8'hF0, 8'h0F},
        {1'b0, 1'b0, 7'd5,   8'h00, 8'hE7},
        {1'b1, 1'b1, 7'd127, 8'h69, 8'h1B}
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] v;
        int          n;
        longint      t0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(3'd2, v); chk(v == 16'h0000, "R1 ctrl", v, 0);
        rd_reg(3'd4, v); chk(v == 16'h0000, "R1 status", v, 0);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);

        // R2 control field retention
        wr_reg(3'd2, 16'hFFFF);
        rd_reg(3'd2, v); chk(v == 16'hFF81, "R2 ctrl readback", v, 16'hFF81);
        wr_reg(3'd2, 16'h0000);
        rd_reg(3'd2, v); chk(v == 16'h0000, "R2 ctrl cleared", v, 0);

        // R9 data write while disabled
        wr_reg(3'd0, 16'h00C3);
        repeat (6) @(negedge clk);
        rd_reg(3'd4, v); chk(v == 16'h0000, "R9 status after disabled write", v, 0);
        chk(sclk == 1'b0, "R9 sclk idle", sclk, 0);

        // Table of transfers: R3 R4 R5 R6 R7 R11
        for (int i = 0; i < 6; i++) begin
            logic       pol, pha;
            logic [6:0] dv;
            logic [7:0] tx, sv;
            {pol, pha, dv, tx, sv} = VEC[i];
            wr_reg(3'd2, ctrl_word(1'b1, pol, pha, dv));
            repeat (2) @(negedge clk);
            chk(sclk == pol, "R5 idle level", sclk, pol);
            arm_slave(pol, pha, dv, sv);
            wr_reg(3'd0, {8'h00, tx});
            wait_idle(n);
            slv_on = 1'b0;
            chk(n == 16 * (int'(dv) + 1), "R3 busy length", n, 16 * (int'(dv) + 1));
            chk(slv_edges == 16, "R5 edge count", slv_edges, 16);
            chk(gap_err == 0, "R5 half period", gap_err, 0);
            chk(sclk == pol, "R5 rest after exchange", sclk, pol);
            chk(slv_rx == tx, "R6 R4 serial output byte", slv_rx, tx);
            rd_reg(3'd4, v); chk(v == 16'h0002, "R11 R7 status full", v, 2);
            rd_reg(3'd0, v); chk(v == {8'h00, sv}, "R4 R6 received byte", v, sv);
            rd_reg(3'd4, v); chk(v == 16'h0000, "R7 full cleared by read", v, 0);
        end

        // R8 data write while busy is ignored
        wr_reg(3'd2, ctrl_word(1'b1, 1'b0, 1'b0, 7'd3));
        repeat (2) @(negedge clk);
        arm_slave(1'b0, 1'b0, 7'd3, 8'h55);
        wr_reg(3'd0, 16'h00A5);
        t0 = $time;
        repeat (10) @(negedge clk);
        wr_reg(3'd0, 16'h0000);
        wait_idle(n);
        slv_on = 1'b0;
        n = int'(($time - t0) / 10);
        chk(n == 64, "R8 length unchanged", n, 64);
        chk(slv_rx == 8'hA5, "R8 byte unchanged", slv_rx, 8'hA5);
        rd_reg(3'd0, v); chk(v == 16'h0055, "R8 received byte", v, 16'h55);

        // R10 abort by clearing enable
        wr_reg(3'd2, ctrl_word(1'b1, 1'b1, 1'b0, 7'd2));
        repeat (2) @(negedge clk);
        wr_reg(3'd0, 16'h00FF);
        repeat (20) @(negedge clk);
        wr_reg(3'd2, ctrl_word(1'b0, 1'b1, 1'b0, 7'd2));
        #1;
        chk(sclk == 1'b1, "R10 sclk parked", sclk, 1);
        rd_reg(3'd4, v); chk(v == 16'h0000, "R10 stopped without full", v, 0);
        repeat (60) @(negedge clk);
        rd_reg(3'd4, v); chk(v == 16'h0000, "R10 stays stopped", v, 0);
        chk(sclk == 1'b1, "R10 sclk still parked", sclk, 1);

        // Recovery after abort
        wr_reg(3'd2, ctrl_word(1'b1, 1'b0, 1'b0, 7'd0));
        repeat (2) @(negedge clk);
        arm_slave(1'b0, 1'b0, 7'd0, 8'h2D);
        wr_reg(3'd0, 16'h00B4);
        wait_idle(n);
        slv_on = 1'b0;
        chk(slv_rx == 8'hB4, "R4 after abort output", slv_rx, 8'hB4);
        rd_reg(3'd0, v); chk(v == 16'h002D, "R4 after abort input", v, 16'h2D);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule